// File: doc/BRIEF.md
# Staggered-PRI Chirp Sequence Scheduler

This block sets the transmit and receive timing for one radar frame. A frame is built from up to three sub-frames, one for each chirp waveform: SHORT, MEDIUM and LONG. Each sub-frame is a run of identical chirps. Every chirp has a transmit window followed at once by a listen window. The host sets the cycle count of each window separately for each waveform. Because of this, each waveform can have its own pulse repetition interval, and the three intervals differ. A later stage needs those distinct intervals to resolve Doppler aliases, so every chirp is tagged with the sub-frame it belongs to.

A one-cycle start strobe begins a frame. The scheduler walks through the enabled sub-frames in a fixed order. After the last listen window it runs a single guard interval, then raises a one-cycle frame-done pulse. At a 100 MHz timing clock, a typical setting is:

| Waveform | Transmit cycles | Listen cycles | PRI |
|---|---|---|---|
| SHORT | 100 | 17400 | 175 µs |
| MEDIUM | 500 | 15600 | 161 µs |
| LONG | 3000 | 13700 | 167 µs |

The usual setting is 16 chirps per sub-frame, which gives 48 chirps per frame. The usual guard is 17540 cycles.

Top module: `chirp_sched`

## Requirements
- R1: After synchronous reset, `tx_active`, `rx_active`, `chirp_start` and `frame_done` are all 0, and the scheduler is idle.
- R2: Enabled sub-frames run in the order SHORT, MEDIUM, LONG. A sub-frame whose enable bit is 0 is skipped. The last listen cycle of one sub-frame is followed directly by the first transmit cycle of the next enabled sub-frame, with no dead cycle.
- R3: Each chirp holds `tx_active` for the transmit length of its sub-frame. It then holds `rx_active` for the listen length of that sub-frame, starting in the next cycle. A programmed length of 0 behaves as a length of 1.
- R4: Each enabled sub-frame emits `CHIRPS` chirps, with `chirp_idx` running from 0 to CHIRPS-1. `sub_id` is 0 for SHORT, 1 for MEDIUM and 2 for LONG. Enable bit i of `sub_en` (bit 0 = SHORT, bit 1 = MEDIUM, bit 2 = LONG) enables sub-frame ID i.
- R5: `chirp_start` is a one-cycle pulse in the first transmit cycle of every chirp. `sub_id` and `chirp_idx` hold that chirp's values for the whole chirp.
- R6: After the last listen window, both activity outputs stay low for `guard_len` cycles (0 behaves as 1). In the following cycle `frame_done` pulses for one cycle.
- R7: When `sub_en` is 3'b000, a start strobe is ignored. No chirp and no `frame_done` follow.
- R8: A start strobe is ignored while a frame is in progress, including the guard interval. Start is sampled again in the `frame_done` cycle. If start is held high, the next frame's first `chirp_start` therefore appears in the cycle after `frame_done`.
- R9: `tx_active` and `rx_active` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Frame start strobe, sampled while idle |
| sub_en | input | 3 | Sub-frame enable mask, bit i enables ID i; sampled at start |
| short_tx_len | input | CNT_W | SHORT transmit length in cycles |
| short_rx_len | input | CNT_W | SHORT listen length in cycles |
| med_tx_len | input | CNT_W | MEDIUM transmit length in cycles |
| med_rx_len | input | CNT_W | MEDIUM listen length in cycles |
| long_tx_len | input | CNT_W | LONG transmit length in cycles |
| long_rx_len | input | CNT_W | LONG listen length in cycles |
| guard_len | input | CNT_W | Guard interval in cycles after the last listen window |
| tx_active | output | 1 | High during a transmit window |
| rx_active | output | 1 | High during a listen window |
| chirp_start | output | 1 | One-cycle pulse at the first transmit cycle of each chirp |
| sub_id | output | 2 | Sub-frame ID of the current chirp |
| chirp_idx | output | IDX_W | Chirp index within the current sub-frame |
| frame_done | output | 1 | One-cycle pulse at the end of the frame |

## Verification
Two events can fall in the same cycle. One is the `frame_done` pulse. The other is the acceptance of a new start strobe, because the scheduler is already idle in the `frame_done` cycle. The bench provokes this by holding `start` high across two frames. It then judges that the next `chirp_start` appears exactly one cycle after `frame_done`, that no extra frame is launched, and that the scoreboard still matches every chirp's sub-frame, index and window lengths. A second collision is also exercised: when a sub-frame ends, the final listen cycle and the switch to the next enabled sub-frame land on the same edge. The scoreboard checks that the new sub-frame starts with index 0 and no gap.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_SUB = 3;
  typedef logic [1:0] sub_t;
  localparam sub_t SUB_SHORT = 2'd0;
  localparam sub_t SUB_MED   = 2'd1;
  localparam sub_t SUB_LONG  = 2'd2;
  typedef enum logic [1:0] {PH_IDLE, PH_TX, PH_RX, PH_GUARD} phase_e;
endpackage

// File: rtl/sched_pick.sv
// Finds the lowest-numbered enabled sub-frame, either from the beginning
// of the frame or strictly after the current one.
module sched_pick
  import sched_pkg::*;
#(
  parameter int N = NUM_SUB
) (
  input  logic [N-1:0] mask,
  input  sub_t         cur,
  input  logic         from_first,
  output logic         found,
  output sub_t         sel
);
  always_comb begin
    found = 1'b0;
    sel   = SUB_SHORT;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i] && (from_first || i > int'(cur))) begin
        found = 1'b1;
        sel   = sub_t'(i);
      end
    end
  end
endmodule

// File: rtl/sched_timer.sv
// Down-counter for one interval. A load of N gives N cycles before done;
// a load of 0 is treated as 1.
module sched_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] len,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= (len == '0) ? '0 : len - 1'b1;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign last = (cnt == '0);
endmodule

// File: rtl/chirp_sched.sv
module chirp_sched
  import sched_pkg::*;
#(
  parameter int  CNT_W  = 16,
  parameter int  CHIRPS = 16,
  localparam int IDX_W  = (CHIRPS > 1) ? $clog2(CHIRPS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [2:0]       sub_en,
  input  logic [CNT_W-1:0] short_tx_len,
  input  logic [CNT_W-1:0] short_rx_len,
  input  logic [CNT_W-1:0] med_tx_len,
  input  logic [CNT_W-1:0] med_rx_len,
  input  logic [CNT_W-1:0] long_tx_len,
  input  logic [CNT_W-1:0] long_rx_len,
  input  logic [CNT_W-1:0] guard_len,
  output logic             tx_active,
  output logic             rx_active,
  output logic             chirp_start,
  output logic [1:0]       sub_id,
  output logic [IDX_W-1:0] chirp_idx,
  output logic             frame_done
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CHIRPS - 1);

  // per-waveform length tables, indexed by sub-frame ID
  logic [CNT_W-1:0] tx_tab [NUM_SUB];
  logic [CNT_W-1:0] rx_tab [NUM_SUB];
  assign tx_tab[SUB_SHORT] = short_tx_len;
  assign tx_tab[SUB_MED]   = med_tx_len;
  assign tx_tab[SUB_LONG]  = long_tx_len;
  assign rx_tab[SUB_SHORT] = short_rx_len;
  assign rx_tab[SUB_MED]   = med_rx_len;
  assign rx_tab[SUB_LONG]  = long_rx_len;

  phase_e           phase_q, phase_n;
  sub_t             sub_q, sub_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [2:0]       mask_q, mask_n;
  logic             cs_q, cs_n;
  logic             done_q, done_n;

  logic             tm_load;
  logic [CNT_W-1:0] tm_len;
  logic             tm_last;

  logic             pk_found;
  sub_t             pk_sel;
  logic             idle;

  assign idle = (phase_q == PH_IDLE);

  sched_pick #(.N(NUM_SUB)) u_pick (
    .mask       (idle ? sub_en : mask_q),
    .cur        (sub_q),
    .from_first (idle),
    .found      (pk_found),
    .sel        (pk_sel)
  );

  sched_timer #(.W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tm_load),
    .len  (tm_len),
    .last (tm_last)
  );

  always_comb begin
    phase_n = phase_q;
    sub_n   = sub_q;
    idx_n   = idx_q;
    mask_n  = mask_q;
    cs_n    = 1'b0;
    done_n  = 1'b0;
    tm_load = 1'b0;
    tm_len  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (start && pk_found) begin
          phase_n = PH_TX;
          sub_n   = pk_sel;
          idx_n   = '0;
          mask_n  = sub_en;
          cs_n    = 1'b1;
          tm_load = 1'b1;
          tm_len  = tx_tab[pk_sel];
        end
      end
      PH_TX: begin
        if (tm_last) begin
          phase_n = PH_RX;
          tm_load = 1'b1;
          tm_len  = rx_tab[sub_q];
        end
      end
      PH_RX: begin
        if (tm_last) begin
          if (idx_q != LAST_IDX) begin
            phase_n = PH_TX;
            idx_n   = idx_q + 1'b1;
            cs_n    = 1'b1;
            tm_load = 1'b1;
            tm_len  = tx_tab[sub_q];
          end else if (pk_found) begin
            phase_n = PH_TX;
            sub_n   = pk_sel;
            idx_n   = '0;
            cs_n    = 1'b1;
            tm_load = 1'b1;
            tm_len  = tx_tab[pk_sel];
          end else begin
            phase_n = PH_GUARD;
            tm_load = 1'b1;
            tm_len  = guard_len;
          end
        end
      end
      PH_GUARD: begin
        if (tm_last) begin
          phase_n = PH_IDLE;
          done_n  = 1'b1;
        end
      end
      default: phase_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      sub_q   <= SUB_SHORT;
      idx_q   <= '0;
      mask_q  <= '0;
      cs_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_n;
      sub_q   <= sub_n;
      idx_q   <= idx_n;
      mask_q  <= mask_n;
      cs_q    <= cs_n;
      done_q  <= done_n;
    end
  end

  assign tx_active   = (phase_q == PH_TX);
  assign rx_active   = (phase_q == PH_RX);
  assign chirp_start = cs_q;
  assign sub_id      = sub_q;
  assign chirp_idx   = idx_q;
  assign frame_done  = done_q;
endmodule

// File: rtl/chirp_sched_chk.sv
module chirp_sched_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_active,
  input logic             rx_active,
  input logic             chirp_start,
  input logic [1:0]       sub_id,
  input logic [IDX_W-1:0] chirp_idx,
  input logic             frame_done
);
  AST_TX_RX_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(tx_active && rx_active)); // R9

  AST_START_IN_TX: assert property (@(posedge clk) disable iff (rst)
    chirp_start |-> tx_active); // R5

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    chirp_start |=> !chirp_start); // R5

  AST_TX_ROSE_START: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_active) |-> chirp_start); // R5

  AST_RX_AFTER_TX: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_active) |-> $past(tx_active)); // R3

  AST_SUB_HELD: assert property (@(posedge clk) disable iff (rst)
    (chirp_start && chirp_idx != '0) |-> $stable(sub_id)); // R4

  AST_SUB_CODE: assert property (@(posedge clk) disable iff (rst)
    (tx_active || rx_active) |-> sub_id != 2'd3); // R4

  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!tx_active && !rx_active && !$past(rx_active))); // R6

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R6
endmodule

bind chirp_sched chirp_sched_chk #(.IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_active   (tx_active),
  .rx_active   (rx_active),
  .chirp_start (chirp_start),
  .sub_id      (sub_id),
  .chirp_idx   (chirp_idx),
  .frame_done  (frame_done)
);

// File: tb/tb_chirp_sched.sv
module tb_chirp_sched;
  localparam int CNT_W  = 16;
  localparam int CHIRPS = 16;
  localparam int IDX_W  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [2:0] sub_en = 3'b111;
  int   tx_cfg [3];
  int   rx_cfg [3];
  int   guard_cfg;

  logic             tx_active, rx_active, chirp_start, frame_done;
  logic [1:0]       sub_id;
  logic [IDX_W-1:0] chirp_idx;

  always #5 clk = ~clk;

  chirp_sched #(.CNT_W(CNT_W), .CHIRPS(CHIRPS)) dut (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .sub_en       (sub_en),
    .short_tx_len (CNT_W'(tx_cfg[0])),
    .short_rx_len (CNT_W'(rx_cfg[0])),
    .med_tx_len   (CNT_W'(tx_cfg[1])),
    .med_rx_len   (CNT_W'(rx_cfg[1])),
    .long_tx_len  (CNT_W'(tx_cfg[2])),
    .long_rx_len  (CNT_W'(rx_cfg[2])),
    .guard_len    (CNT_W'(guard_cfg)),
    .tx_active    (tx_active),
    .rx_active    (rx_active),
    .chirp_start  (chirp_start),
    .sub_id       (sub_id),
    .chirp_idx    (chirp_idx),
    .frame_done   (frame_done)
  );

  typedef struct {
    bit is_end;
    int sub;
    int idx;
    int tx;
    int rx;
    int guard;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  int frames_seen = 0;
  int starts_seen = 0;

  task automatic check(input bit ok, input string req, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  function automatic int eff(input int n);
    return (n == 0) ? 1 : n;
  endfunction

  // driver side: expected chirp list for one frame with the current setup
  task automatic push_frame(input logic [2:0] m);
    exp_t e;
    if (m == 3'b000) return;
    for (int s = 0; s < 3; s++) begin
      if (m[s]) begin
        for (int i = 0; i < CHIRPS; i++) begin
          e = '{is_end: 1'b0, sub: s, idx: i, tx: eff(tx_cfg[s]),
                rx: eff(rx_cfg[s]), guard: 0};
          exp_q.push_back(e);
        end
      end
    end
    e = '{is_end: 1'b1, sub: 0, idx: 0, tx: 0, rx: 0, guard: eff(guard_cfg)};
    exp_q.push_back(e);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // monitor side
  bit open = 1'b0;
  int m_sub, m_idx, m_tx, m_rx, m_gap;

  task automatic close_chirp();
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R2,R4", $sformatf("unexpected chirp sub %0d idx %0d, expected none",
                                       m_sub, m_idx));
      return;
    end
    e = exp_q.pop_front();
    check(!e.is_end && e.sub == m_sub && e.idx == m_idx && e.tx == m_tx && e.rx == m_rx,
          "R2,R3,R4",
          $sformatf("chirp actual end=0 sub=%0d idx=%0d tx=%0d rx=%0d expected end=%0d sub=%0d idx=%0d tx=%0d rx=%0d",
                    m_sub, m_idx, m_tx, m_rx, e.is_end, e.sub, e.idx, e.tx, e.rx));
  endtask

  task automatic close_frame();
    exp_t e;
    if (exp_q.size() == 0) begin
      check(1'b0, "R6", "unexpected frame_done, expected none");
      return;
    end
    e = exp_q.pop_front();
    check(e.is_end && e.guard == m_gap, "R6",
          $sformatf("frame end actual guard=%0d expected end=1 guard=%0d (got end=%0d)",
                    m_gap, e.guard, e.is_end));
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (chirp_start) begin
        if (open) close_chirp();
        starts_seen++;
        open  = 1'b1;
        m_sub = int'(sub_id);
        m_idx = int'(chirp_idx);
        m_tx  = 0;
        m_rx  = 0;
        m_gap = 0;
      end
      if (frame_done) begin
        if (open) close_chirp();
        close_frame();
        open = 1'b0;
        frames_seen++;
      end else if (open) begin
        if (tx_active) m_tx++;
        if (rx_active) m_rx++;
        if (!tx_active && !rx_active) m_gap++;
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung, expected finish");
    finish_run();
  end

  initial begin
    int f0, s0;
    tx_cfg = '{2, 4, 1};
    rx_cfg = '{3, 2, 5};
    guard_cfg = 6;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    check(tx_active == 1'b0, "R1", $sformatf("tx_active actual %0b expected 0", tx_active));
    check(rx_active == 1'b0, "R1", $sformatf("rx_active actual %0b expected 0", rx_active));
    check(chirp_start == 1'b0, "R1", $sformatf("chirp_start actual %0b expected 0", chirp_start));
    check(frame_done == 1'b0, "R1", $sformatf("frame_done actual %0b expected 0", frame_done));

    // full frame, all enabled; a second start mid-frame must be ignored (R8)
    sub_en = 3'b111;
    push_frame(sub_en);
    f0 = frames_seen;
    pulse_start();
    repeat (100) @(negedge clk);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait (frames_seen == f0 + 1);
    s0 = starts_seen;
    repeat (10) @(negedge clk);
    check(starts_seen == s0, "R8",
          $sformatf("chirps after frame actual %0d expected 0", starts_seen - s0));

    // MEDIUM disabled: skipped with no gap (R2)
    sub_en = 3'b101;
    push_frame(sub_en);
    f0 = frames_seen;
    pulse_start();
    wait (frames_seen == f0 + 1);

    // only LONG, zero-length MEDIUM irrelevant; then zero lengths elsewhere (R3,R6)
    sub_en = 3'b100;
    push_frame(sub_en);
    f0 = frames_seen;
    pulse_start();
    wait (frames_seen == f0 + 1);

    tx_cfg = '{3, 0, 2};
    rx_cfg = '{0, 4, 1};
    guard_cfg = 0;
    sub_en = 3'b011;
    push_frame(sub_en);
    f0 = frames_seen;
    pulse_start();
    wait (frames_seen == f0 + 1);

    // R7: empty mask, nothing happens
    sub_en = 3'b000;
    s0 = starts_seen;
    f0 = frames_seen;
    pulse_start();
    repeat (30) @(negedge clk);
    check(starts_seen == s0, "R7", $sformatf("chirps actual %0d expected 0", starts_seen - s0));
    check(frames_seen == f0, "R7", $sformatf("frames actual %0d expected 0", frames_seen - f0));

    // R8: start held high across the frame_done cycle -> back-to-back frames
    tx_cfg = '{2, 3, 2};
    rx_cfg = '{2, 2, 3};
    guard_cfg = 4;
    sub_en = 3'b010;
    push_frame(sub_en);
    push_frame(sub_en);
    f0 = frames_seen;
    @(negedge clk); start = 1'b1;
    wait (frames_seen == f0 + 1);
    @(negedge clk);
    check(chirp_start == 1'b1 && sub_id == 2'd1 && chirp_idx == '0, "R8",
          $sformatf("cycle after frame_done actual start=%0b sub=%0d idx=%0d expected start=1 sub=1 idx=0",
                    chirp_start, sub_id, chirp_idx));
    start = 1'b0;
    wait (frames_seen == f0 + 2);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R4",
          $sformatf("pending expected items actual %0d expected 0", exp_q.size()));
    finish_run();
  end
endmodule